// File: doc/BRIEF.md
# Dual-Port Two-Beat Burst Static Memory Model

This block is a synthesizable behavioural model of a static memory with separate read and write request pins and double-data-rate transfers. Every access moves a two-beat line. Beat 0 moves on the rising clock edge and beat 1 moves on the falling edge. A write is requested on a rising edge, and its line address arrives on the falling edge that follows. Its two data beats and their active-low lane enables arrive on those same two edges. A read supplies its line address on the rising edge that requests it. Its two beats come back 1.5 and 2 cycles later.

Writes are posted. A captured burst moves into a single pending register one cycle after its request, and it reaches the array one cycle after that. A read that arrives while its line is still pending takes the enabled lanes from the pending register and the other lanes from the array. This lets a write be followed at once by a read of the same line. A new write and a new read may each start on every rising edge. Lanes are 4 bits wide for an 8-bit word and 9 bits wide for the 9, 18 and 36-bit words.

Top module: `qdr2_b2_sram`

## Requirements
- R1: A write starts when `wr_n` is low at a rising edge of `clk`. Beat 0 of its data and its lane enables are taken from `wdata` and `be_n` on that same edge.
- R2: The line address of that write is taken from `addr` on the next falling edge. Beat 1 of the data and its enables are taken from `wdata` and `be_n` on that same falling edge.
- R3: A write may start on every rising edge with no idle cycle between writes. After a run of writes, each line holds the value of the last write to it.
- R4: A read starts when `rd_n` is low at a rising edge, and its line address is taken from `addr` on that edge. Beat 0 appears on `rdata` during the low phase that begins 1.5 cycles after the request. Beat 1 appears during the high phase that follows. `rvalid` is high across both beats.
- R5: A read requested on the rising edge right after a write's rising edge, to the same line, returns the data of that write.
- R6: `be_n` is active low, and bit i enables lane i. A disabled lane keeps its old contents. A read of a line that is still pending merges lane by lane: written lanes come from the pending data and the others come from the array.
- R7: A lane is 4 bits wide when WIDTH is 8 and 9 bits wide otherwise. Lane i occupies bits [i*LW +: LW]. WIDTH must be 8, 9, 18 or 36.
- R8: A write that starts on the same rising edge as a read of the same line is not seen by that read. The read returns the line's previous contents.
- R9: While `rst_n` is low (sampled on both edges), `rvalid` is 0 and `rdata` is 0, and any read or write in flight is dropped.
- R10: When no read was requested 1.5 cycles earlier, `rvalid` is 0 and `rdata` is all zeros in both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its rising edge plays K and its falling edge plays K# |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Read request, active low, sampled on rising edge |
| wr_n | input | 1 | Write request, active low, sampled on rising edge |
| addr | input | AW | Read line address (rising edge) or write line address (falling edge) |
| wdata | input | WIDTH | Write beat 0 (rising edge) and beat 1 (falling edge) |
| be_n | input | NL | Active-low lane enables for the beat on the same edge |
| rdata | output | WIDTH | Read beat 0 in the low phase, beat 1 in the high phase |
| rvalid | output | 1 | High while `rdata` carries read data |

## Verification
A pending register that is lost or goes stale appears within two cycles as a wrong beat on a read that follows a write at once. An array commit with the wrong lane mask appears on the first later read of that line, after the forwarding window has closed. A slip in the read pipeline moves `rvalid` and the data by one phase, which fails the check of the very next read and of the idle phases around it. The bench keeps collisions frequent by confining mixed traffic to four lines, so state errors surface within a few cycles of their cause.

// File: rtl/qdr2_b2_sram.sv
module qdr2_b2_sram #(
  parameter int WIDTH = 18,
  parameter int AW    = 4,
  localparam int LW   = (WIDTH == 8) ? 4 : 9,
  localparam int NL   = WIDTH / LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [NL-1:0]    be_n,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);
  localparam int LINES = 1 << AW;

  logic [WIDTH-1:0] mem [LINES][2];

  logic             w1_v;
  logic [AW-1:0]    w1_a;
  logic [WIDTH-1:0] w1_d0, w1_d1;
  logic [NL-1:0]    w1_b0, w1_b1;

  logic             p_v;
  logic [AW-1:0]    p_a;
  logic [WIDTH-1:0] p_d0, p_d1;
  logic [NL-1:0]    p_b0, p_b1;

  logic             rq_v;
  logic [AW-1:0]    rq_a;
  logic             rb_v;
  logic [WIDTH-1:0] rb0, rb1;
  logic [WIDTH-1:0] rn_d, rp_d;

  function automatic logic [WIDTH-1:0] lane_mix(input logic [WIDTH-1:0] old,
                                                input logic [WIDTH-1:0] nw,
                                                input logic [NL-1:0] en_n);
    logic [WIDTH-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++)
      if (!en_n[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  logic             hit;
  logic [WIDTH-1:0] fwd0, fwd1;
  assign hit  = p_v && (p_a == rq_a);
  assign fwd0 = hit ? lane_mix(mem[rq_a][0], p_d0, p_b0) : mem[rq_a][0];
  assign fwd1 = hit ? lane_mix(mem[rq_a][1], p_d1, p_b1) : mem[rq_a][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w1_v <= 1'b0;
      p_v  <= 1'b0;
      rq_v <= 1'b0;
      rb_v <= 1'b0;
      rp_d <= '0;
    end else begin
      w1_v <= !wr_n;
      if (!wr_n) begin
        w1_d0 <= wdata;
        w1_b0 <= be_n;
      end
      p_v  <= w1_v;
      p_a  <= w1_a;
      p_d0 <= w1_d0;
      p_d1 <= w1_d1;
      p_b0 <= w1_b0;
      p_b1 <= w1_b1;
      rq_v <= !rd_n;
      if (!rd_n) rq_a <= addr;
      rb_v <= rq_v;
      rb0  <= fwd0;
      rb1  <= fwd1;
      rp_d <= rvalid ? rb1 : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && p_v) begin
      mem[p_a][0] <= lane_mix(mem[p_a][0], p_d0, p_b0);
      mem[p_a][1] <= lane_mix(mem[p_a][1], p_d1, p_b1);
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rn_d   <= '0;
    end else begin
      rvalid <= rb_v;
      rn_d   <= rb_v ? rb0 : '0;
      if (w1_v) begin
        w1_a  <= addr;
        w1_d1 <= wdata;
        w1_b1 <= be_n;
      end
    end
  end

  assign rdata = clk ? rp_d : rn_d;

  initial AST_WIDTH_LEGAL: assert (WIDTH == 8 || WIDTH == 9 || WIDTH == 18 || WIDTH == 36);  // R7

  AST_READ_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> ##1 rvalid);  // R4

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> ##1 !rvalid);  // R10

  AST_WRITE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> ##1 p_v);  // R3

  AST_FWD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_v && p_v && p_a == rq_a && p_b0 == '0) |=> rb0 == $past(p_d0));  // R5
endmodule

// File: tb/qdr2_b2_sram_test.sv
module qdr2_b2_sram_test;
  localparam int W = 18, AW = 4, LW = 9, NL = 2, LINES = 16;

  logic clk = 1'b0, rst_n = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [NL-1:0] be_n = '1;
  logic [W-1:0] rdata;
  logic rvalid;

  qdr2_b2_sram #(.WIDTH(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .be_n(be_n), .rdata(rdata), .rvalid(rvalid));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [W-1:0] refm [LINES][2];
  logic e_v [2];
  logic [W-1:0] e0 [2], e1 [2];
  string e_tag [2];
  logic [15:0] lf = 16'hACE1;

  function automatic logic [W-1:0] mix(input logic [W-1:0] o, input logic [W-1:0] n,
                                       input logic [NL-1:0] b);
    logic [W-1:0] r = o;
    for (int i = 0; i < NL; i++) if (b[i] == 1'b0) r[i*LW +: LW] = n[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [W-1:0] pat(input int l, input int w, input int s);
    return W'(l * 1031 + w * 517 + s * 4099 + 99);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic dw, input int wa, input logic [W-1:0] d0, input logic [W-1:0] d1,
                     input logic [NL-1:0] b0, input logic [NL-1:0] b1,
                     input logic dr, input int ra, input string tag);
    @(negedge clk); #1;
    chk({e_tag[1], " rvalid low phase"}, W'(rvalid), W'(e_v[1]));
    chk({e_tag[1], " beat0"}, rdata, e_v[1] ? e0[1] : '0);
    wr_n = !dw; rd_n = !dr;
    addr = dr ? AW'(ra) : '0;
    wdata = dw ? d0 : '0;
    be_n = b0;
    @(posedge clk); #1;
    chk({e_tag[1], " rvalid high phase"}, W'(rvalid), W'(e_v[1]));
    chk({e_tag[1], " beat1"}, rdata, e_v[1] ? e1[1] : '0);
    e_v[1] = e_v[0]; e0[1] = e0[0]; e1[1] = e1[0]; e_tag[1] = e_tag[0];
    e_v[0] = dr && rst_n; e_tag[0] = tag;
    e0[0] = refm[ra % LINES][0]; e1[0] = refm[ra % LINES][1];
    if (dw && rst_n) begin
      refm[wa][0] = mix(refm[wa][0], d0, b0);
      refm[wa][1] = mix(refm[wa][1], d1, b1);
    end
    addr = AW'(wa); wdata = d1; be_n = b1;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 0, '0, '0, '1, '1, 1'b0, 0, tag);
  endtask

  task automatic done();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    done();
  end

  initial begin
    for (int l = 0; l < LINES; l++) begin refm[l][0] = '0; refm[l][1] = '0; end
    for (int i = 0; i < 2; i++) begin e_v[i] = 1'b0; e0[i] = '0; e1[i] = '0; e_tag[i] = "R9"; end
    // R9: outputs held at zero during reset, even with requests on the pins
    for (int i = 0; i < 4; i++) cyc(1'b1, 3, '1, '1, '0, '0, 1'b1, 3, "R9");
    rst_n = 1'b1;
    idle("R9 R10"); idle("R9 R10");
    // R1 R2 R3: back-to-back writes fill every line
    for (int l = 0; l < LINES; l++)
      cyc(1'b1, l, pat(l, 0, 1), pat(l, 1, 1), '0, '0, 1'b0, 0, "R1 R2 R3");
    // R4: back-to-back reads of every line
    for (int l = 0; l < LINES; l++) cyc(1'b0, 0, '0, '0, '1, '1, 1'b1, l, "R4");
    idle("R10"); idle("R10"); idle("R10");
    // R5: read on the edge right after a write to the same line
    for (int l = 0; l < LINES; l++) begin
      cyc(1'b1, l, pat(l, 0, 2), pat(l, 1, 2), '0, '0, 1'b0, 0, "R5");
      cyc(1'b0, 0, '0, '0, '1, '1, 1'b1, l, "R5");
    end
    // R8: write and read of one line on the same edge
    for (int l = 0; l < LINES; l += 3) begin
      cyc(1'b1, l, pat(l, 0, 3), pat(l, 1, 3), '0, '0, 1'b1, l, "R8");
      cyc(1'b0, 0, '0, '0, '1, '1, 1'b1, l, "R8 R5");
    end
    // R6 R7: every lane-enable pair, forwarded read then array read
    for (int b0 = 0; b0 < 4; b0++)
      for (int b1 = 0; b1 < 4; b1++) begin
        int l = b0 * 4 + b1;
        cyc(1'b1, l, pat(l, 0, 4), pat(l, 1, 4), NL'(b0), NL'(b1), 1'b0, 0, "R6 R7 write");
        cyc(1'b0, 0, '0, '0, '1, '1, 1'b1, l, "R6 R7 forwarded");
        idle("R10"); idle("R10");
        cyc(1'b0, 0, '0, '0, '1, '1, 1'b1, l, "R6 R7 array");
      end
    // R3 R5 R6: mixed traffic on four lines
    for (int i = 0; i < 600; i++) begin
      logic [15:0] s;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      s = lf;
      cyc(s[0] | s[1], int'(s[3:2]), pat(i, 0, int'(s[15:8])), pat(i, 1, int'(s[15:8])),
          NL'(s[5:4]), NL'(s[7:6]), s[8] | s[9], int'(s[11:10]), "R3 R5 R6 mixed");
    end
    idle("R10"); idle("R10"); idle("R10");
    done();
  end
endmodule